// File: doc/BRIEF.md
# Status Flags and Interrupt Unit

This unit holds the readable status and interrupt-status state for a memory-backed scan engine. Each cycle it compares a write pointer with a read pointer into a power-of-two deep buffer and derives four occupancy flags: empty, half-empty, half-full and full. It also captures a 32-bit result word when strobed, keeps a single compare-result bit with its own load and clear, and mirrors a sequencer-active bit and three vector-active bits. The flags and the activity bits are always updated, whatever the interrupt enables say.

When an occupancy flag goes from clear to set and its enable is on, the matching interrupt-status bit sets. The interrupt line is the OR of the enabled interrupt-status bits. A bus read of the interrupt status clears every bit in it. An event that lands in the same cycle as that read is held for one cycle and set after the read, so it is not lost.

Top module: `stat_irq_unit`

## Requirements
- R1: While reset is asserted, `status_word`, `int_status`, `result_lo` and `result_hi` read zero and `irq` is low.
- R2: Occupancy is `(wr_ptr - rd_ptr) mod 2**PTR_W`. One clock edge after the pointers settle, `status_word[0]` (empty) is 1 exactly when occupancy is 0, and `status_word[3]` (full) is 1 exactly when occupancy is `2**PTR_W - 1`.
- R3: One clock edge after the pointers settle, `status_word[2]` (half-full) is 1 when occupancy is at least `2**(PTR_W-1)`, and `status_word[1]` (half-empty) is 1 when occupancy is at most `2**(PTR_W-1)`. Pointer wrap-around is handled by the modulo.
- R4: The four occupancy flags update even when all bits of `irq_en` are zero.
- R5: One edge after they are sampled, `seq_active` shows in `status_word[5]` and `vec_active[2:0]` shows in `status_word[8:6]`, whatever `irq_en` holds. Bits 15:9 and bit 4 are described elsewhere or read zero.
- R6: On an edge with `res_strobe` high, `result_lo` loads `res_word[15:0]` and `result_hi` loads `res_word[31:16]`. Without the strobe, both hold.
- R7: `status_word[4]` (compare bit) takes `cmp_bit` on an edge with `cmp_load` high. It becomes 0 on an edge with `cmp_clear` high, and clear wins over load. Otherwise it holds.
- R8: `int_status[k]` sets on the edge where occupancy flag k goes from 0 to 1 while `irq_en[k]` is 1. The mapping is 0 = empty, 1 = half-empty, 2 = half-full, 3 = full.
- R9: `irq` equals the OR of `int_status & irq_en`. It falls as soon as the enabled bits are cleared or masked.
- R10: An edge with `istat_rd` high leaves `int_status` at zero.
- R11: An interrupt event on the same edge as a read appears in `int_status` on the following edge, as long as that edge is not a read.
- R12: A flag that rises while its enable is 0 sets no `int_status` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ptr | input | PTR_W | Buffer write pointer |
| rd_ptr | input | PTR_W | Buffer read pointer |
| res_word | input | 32 | Result word to capture |
| res_strobe | input | 1 | Capture strobe for `res_word` |
| cmp_bit | input | 1 | Compare-result value |
| cmp_load | input | 1 | Load `cmp_bit` |
| cmp_clear | input | 1 | Clear the compare bit |
| seq_active | input | 1 | Sequencer running indicator |
| vec_active | input | 3 | Vector running indicators |
| irq_en | input | 4 | Interrupt enables per occupancy flag |
| istat_rd | input | 1 | Bus read of interrupt status (one cycle) |
| status_word | output | 16 | General status register |
| int_status | output | 4 | Interrupt-status register |
| result_lo | output | 16 | Captured result, bits 15:0 |
| result_hi | output | 16 | Captured result, bits 31:16 |
| irq | output | 1 | Interrupt request |

## Verification
A wrong registered flag shows in `status_word` one edge after the pointers move. The same edge shows it in `int_status` and `irq`, as a missing or spurious bit. A lost deferred event shows as an `int_status` that stays zero two edges after a read that coincided with a flag rise. A stuck set-priority bug shows as a nonzero `int_status` on the edge right after a read. Capture and compare faults show on `result_lo`, `result_hi` and `status_word[4]` on the edge after the strobe, or as a changed value when no strobe was given.

// File: rtl/stat_irq_unit.sv
module stat_irq_unit #(
  parameter int PTR_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [31:0]      res_word,
  input  logic             res_strobe,
  input  logic             cmp_bit,
  input  logic             cmp_load,
  input  logic             cmp_clear,
  input  logic             seq_active,
  input  logic [2:0]       vec_active,
  input  logic [3:0]       irq_en,
  input  logic             istat_rd,
  output logic [15:0]      status_word,
  output logic [3:0]       int_status,
  output logic [15:0]      result_lo,
  output logic [15:0]      result_hi,
  output logic             irq
);
  localparam logic [PTR_W-1:0] HALF = PTR_W'(1) << (PTR_W - 1);
  localparam logic [PTR_W-1:0] TOP  = {PTR_W{1'b1}};

  logic [PTR_W-1:0] occ;
  logic [3:0] flag_now, flag_q, flag_ev, pend_q, istat_q;
  logic cmp_q, seq_q;
  logic [2:0] vec_q;

  assign occ = wr_ptr - rd_ptr;
  assign flag_now = {occ == TOP, occ >= HALF, occ <= HALF, occ == '0};
  assign flag_ev  = flag_now & ~flag_q & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= '0;
      seq_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      flag_q  <= flag_now;
      seq_q   <= seq_active;
      vec_q   <= vec_active;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_lo <= '0;
      result_hi <= '0;
    end else if (res_strobe) begin
      result_lo <= res_word[15:0];
      result_hi <= res_word[31:16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cmp_q <= 1'b0;
    else if (cmp_clear)  cmp_q <= 1'b0;
    else if (cmp_load)   cmp_q <= cmp_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      istat_q <= '0;
      pend_q  <= '0;
    end else if (istat_rd) begin
      istat_q <= '0;
      pend_q  <= flag_ev;
    end else begin
      istat_q <= istat_q | pend_q | flag_ev;
      pend_q  <= '0;
    end
  end

  assign status_word = {7'd0, vec_q, seq_q, cmp_q, flag_q};
  assign int_status  = istat_q;
  assign irq         = |(istat_q & irq_en);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (int_status == '0 && !irq && result_lo == '0 && result_hi == '0));

  assert_full_not_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[3] |-> !status_word[0]);

  assert_half_cover_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (status_word[1] || status_word[2]));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_strobe |=> ({result_hi, result_lo} == $past(res_word)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_strobe |=> ($stable(result_lo) && $stable(result_hi)));

  assert_cmp_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_clear |=> !status_word[4]);

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_status != '0));

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    istat_rd |=> (int_status == '0));

  assert_deferred_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (istat_rd && flag_ev != '0) ##1 !istat_rd |=> ((int_status & $past(flag_ev, 2)) == $past(flag_ev, 2)));

  assert_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0 && !istat_rd) |=> (int_status == $past(int_status) | $past(pend_q)));
endmodule

// File: tb/stat_irq_unit_tb_top.sv
module stat_irq_unit_tb_top;
  localparam int PTR_W = 11;
  localparam int DEPTH = 1 << PTR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PTR_W-1:0] wr_ptr = '0, rd_ptr = '0;
  logic [31:0] res_word = '0;
  logic res_strobe = 0, cmp_bit = 0, cmp_load = 0, cmp_clear = 0, seq_active = 0, istat_rd = 0;
  logic [2:0] vec_active = '0;
  logic [3:0] irq_en = '0;
  logic [15:0] status_word, result_lo, result_hi;
  logic [3:0] int_status;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stat_irq_unit #(.PTR_W(PTR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .res_word(res_word),
    .res_strobe(res_strobe), .cmp_bit(cmp_bit), .cmp_load(cmp_load), .cmp_clear(cmp_clear),
    .seq_active(seq_active), .vec_active(vec_active), .irq_en(irq_en), .istat_rd(istat_rd),
    .status_word(status_word), .int_status(int_status), .result_lo(result_lo),
    .result_hi(result_hi), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [3:0] flags_for(int wr, int rd);
    int occ = ((wr - rd) % DEPTH + DEPTH) % DEPTH;
    return {occ == DEPTH - 1, occ >= DEPTH / 2, occ <= DEPTH / 2, occ == 0};
  endfunction

  task automatic set_ptrs(int wr, int rd, string req);
    wr_ptr = PTR_W'(wr); rd_ptr = PTR_W'(rd);
    tick();
    check(req, 32'(status_word[3:0]), 32'(flags_for(wr, rd)));
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) tick();
    check("R1 status", 32'(status_word), 0);
    check("R1 istat", 32'(int_status), 0);
    check("R1 result", {result_hi, result_lo}, 0);
    check("R1 irq", 32'(irq), 0);
    rst_n = 1;
    tick();
    check("R4 flags with enables off", 32'(status_word[3:0]), 32'b0011);
    check("R12 no istat", 32'(int_status), 0);
  endtask

  task automatic t_occupancy();
    set_ptrs(1024, 0, "R3 exactly half");
    set_ptrs(2047, 0, "R2 full");
    set_ptrs(5, 10, "R3 wrapped occupancy");
    set_ptrs(1023, 0, "R3 below half");
    set_ptrs(300, 300, "R2 empty nonzero pointers");
    check("R12 flags rose without enable", 32'(int_status), 0);
  endtask

  task automatic t_activity();
    seq_active = 1; vec_active = 3'b101;
    tick();
    check("R5 activity bits", 32'(status_word[8:5]), 32'b1011);
    seq_active = 0; vec_active = 3'b010;
    tick();
    check("R5 activity bits update", 32'(status_word[8:5]), 32'b0100);
  endtask

  task automatic t_result();
    res_word = 32'hCAFE_1234; res_strobe = 1;
    tick();
    res_strobe = 0;
    check("R6 capture lo", 32'(result_lo), 32'h1234);
    check("R6 capture hi", 32'(result_hi), 32'hCAFE);
    res_word = 32'h5555_AAAA;
    tick();
    check("R6 hold", {result_hi, result_lo}, 32'hCAFE_1234);
  endtask

  task automatic t_compare();
    cmp_bit = 1; cmp_load = 1;
    tick();
    check("R7 load", 32'(status_word[4]), 1);
    cmp_load = 0; cmp_bit = 0;
    tick();
    check("R7 hold", 32'(status_word[4]), 1);
    cmp_bit = 1; cmp_load = 1; cmp_clear = 1;
    tick();
    cmp_load = 0; cmp_clear = 0;
    check("R7 clear wins", 32'(status_word[4]), 0);
  endtask

  task automatic t_irq();
    set_ptrs(100, 0, "R3 setup");
    irq_en = 4'b1000;
    tick();
    check("R12 setup no istat", 32'(int_status), 0);
    wr_ptr = PTR_W'(2047);
    tick();
    check("R8 full sets bit3 only", 32'(int_status), 32'b1000);
    check("R9 irq high", 32'(irq), 1);
    istat_rd = 1;
    tick();
    istat_rd = 0;
    check("R10 cleared on read", 32'(int_status), 0);
    check("R9 irq falls", 32'(irq), 0);
  endtask

  task automatic t_deferred();
    set_ptrs(100, 0, "R3 back to low occupancy");
    irq_en = 4'b1111;
    istat_rd = 1;
    tick();
    istat_rd = 0;
    check("R10 clear before deferred", 32'(int_status), 0);
    wr_ptr = '0; istat_rd = 1;
    tick();
    istat_rd = 0;
    check("R11 read edge shows zero", 32'(int_status), 0);
    tick();
    check("R11 deferred empty bit", 32'(int_status), 32'b0001);
    check("R9 irq from deferred", 32'(irq), 1);
    irq_en = 4'b1110;
    #1;
    check("R9 masked irq low", 32'(irq), 0);
    istat_rd = 1;
    tick();
    istat_rd = 0;
    check("R10 final clear", 32'(int_status), 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_occupancy();
    t_activity();
    t_result();
    t_compare();
    t_irq();
    t_deferred();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule